// File: doc/BRIEF.md
# Hot-Plug Slot Command Controller

This block interprets command writes aimed at a bank of hot-pluggable expansion slots. Each command arrives as a one-cycle strobe with an 8-bit code and an 8-bit target. The block then updates the stored state of the addressed slot: its operating state, its power lamp and its attention lamp. It also accepts secondary-bus speed selections and two all-slot bulk commands. Each outcome is reported through sticky status bits: invalid command, invalid mode, busy, and a command-detected flag.

The block keeps, for each slot, a latch-open flag and a presence code. A hot-plug sense path writes the latch flag through a small side port. When a command drives a slot from a live condition into the fully off condition (disabled with its power lamp off), the block marks the latch open and the slot empty, and latches two event flags. It also emits a one-cycle removal request that carries the slot index, so that logic elsewhere can detach whatever sat in the slot.

The bulk commands walk the slots one per cycle. Busy is held high for the whole walk, and strobes that arrive during the walk are ignored.

Top module: `hpc_cmd_ctrl`

## Requirements
- R1: Every accepted command clears invalid-command and invalid-mode when it is accepted. A single command sets `cmd_detected` at the clock edge that accepts it. A bulk command that proceeds sets `cmd_detected` at the edge that finishes its last slot. `cmd_detected` stays set until a `det_clr` pulse arrives in a cycle in which it is not being set.
- R2: Codes 0x00-0x3F are slot commands. Bits [1:0] request a slot state, bits [3:2] a power lamp value and bits [5:4] an attention lamp value. The target slot is bits [4:0] of `cmd_target`, numbered from 1; bits [7:5] of the target are ignored. A valid slot command updates the addressed slot at its accepting edge.
- R3: Slot state codes are 0 = keep, 1 = powered only, 2 = enabled, 3 = disabled. Lamp codes are 0 = keep, 1 = on, 2 = blink, 3 = off. A zero field leaves that stored value unchanged; a non-zero field replaces it.
- R4: A slot command sets invalid-command and changes no slot field in two cases: its target is 0 or greater than NSLOT, or it requests powered-only on a slot that is currently enabled.
- R5: A slot moves from not-off to off, where off means state disabled and power lamp off. On that change its latch-open flag goes to 1, its presence code goes to 3 (empty), and its latch and presence event flags are set. An `evt_clr` bit clears both event flags of its slot.
- R6: Codes 0x40-0x47 select a bus speed from bits [2:0]. Value 0 is stored in `bus_speed`. Any other value sets invalid-mode and leaves `bus_speed` unchanged.
- R7: Code 0x48 (power all) and code 0x49 (enable all) are rejected when any slot is enabled. A rejected bulk command sets invalid-command and changes no slot.
- R8: An accepted bulk command treats each slot according to its latch. A slot with its latch closed gets state powered-only (0x48) or enabled (0x49) and power lamp on. A slot with its latch open keeps its state and gets power lamp off. The attention lamp is kept in both cases.
- R9: An accepted bulk command raises `sts_busy` at its accepting edge. It then updates slot 0, 1, ... NSLOT-1 on the following edges, one per edge, and busy falls with the last slot. A strobe while busy is ignored.
- R10: `rm_req` is a one-cycle pulse with `rm_idx` set to the 0-based slot index. It appears at the same edge as the field update that turned that slot off.
- R11: Any code above 0x49 sets invalid-command and changes nothing else.
- R12: After reset every slot is disabled, with both lamps off, latch open and presence 3. All status bits, `rm_req` and `bus_speed` are 0.
- R13: A latch write (`mrl_wr_en`) stores `mrl_wr_open` for slot `mrl_wr_idx`. The presence code becomes 3 when the latch is open and 0 when it is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code |
| cmd_target | input | 8 | Command target, bits [4:0] used |
| mrl_wr_en | input | 1 | Latch flag write strobe |
| mrl_wr_idx | input | IDXW | Slot written by the latch port |
| mrl_wr_open | input | 1 | New latch value, 1 = open |
| evt_clr | input | NSLOT | Per-slot event flag clear |
| det_clr | input | 1 | Clears command-detected |
| slot_state | output | 2*NSLOT | Slot states, 2 bits per slot |
| slot_pwr_led | output | 2*NSLOT | Power lamp codes |
| slot_attn_led | output | 2*NSLOT | Attention lamp codes |
| slot_mrl_open | output | NSLOT | Latch-open flags |
| slot_prsnt | output | 2*NSLOT | Presence codes |
| evt_mrl | output | NSLOT | Latched latch-change events |
| evt_prsnt | output | NSLOT | Latched presence-change events |
| sts_busy | output | 1 | Bulk walk in progress |
| sts_inv_cmd | output | 1 | Invalid command |
| sts_inv_mode | output | 1 | Invalid speed mode |
| cmd_detected | output | 1 | Command completed |
| bus_speed | output | 3 | Selected bus speed |
| rm_req | output | 1 | Slot removal request pulse |
| rm_idx | output | IDXW | Slot index of the removal request |

## Verification
The bench builds the block with NSLOT = 3. With that setting the 5-bit target field covers both valid targets 1-3 and out-of-range targets 4-6, and a three-slot bulk walk stays short enough to check at every edge. All 256 command codes are swept against a running arithmetic model of the slots. Latch flips are interleaved so that bulk commands meet a mix of open and closed latches, and meet both the accepted and the rejected path.

// File: rtl/hpc_cmd_pkg.sv
package hpc_cmd_pkg;
  localparam logic [1:0] ST_NONE   = 2'd0;
  localparam logic [1:0] ST_PWR    = 2'd1;
  localparam logic [1:0] ST_EN     = 2'd2;
  localparam logic [1:0] ST_DIS    = 2'd3;
  localparam logic [1:0] LED_NONE  = 2'd0;
  localparam logic [1:0] LED_ON    = 2'd1;
  localparam logic [1:0] LED_OFF   = 2'd3;
  localparam logic [1:0] PRS_LOW   = 2'd0;
  localparam logic [1:0] PRS_EMPTY = 2'd3;

  typedef enum logic [2:0] {
    K_SLOT, K_SPEED, K_BULK_PWR, K_BULK_EN, K_BAD
  } cmd_kind_e;

  typedef struct packed {
    logic [1:0] st;
    logic [1:0] pwr;
    logic [1:0] attn;
  } slot_ctl_t;
endpackage

// File: rtl/hpc_cmd_decode.sv
module hpc_cmd_decode
  import hpc_cmd_pkg::*;
(
  input  logic [7:0] code,
  output cmd_kind_e  kind,
  output slot_ctl_t  req,
  output logic [2:0] speed
);
  always_comb begin
    req.st   = code[1:0];
    req.pwr  = code[3:2];
    req.attn = code[5:4];
    speed    = code[2:0];
    if (code[7:6] == 2'b00)          kind = K_SLOT;
    else if (code[7:3] == 5'b01000)  kind = K_SPEED;
    else if (code == 8'h48)          kind = K_BULK_PWR;
    else if (code == 8'h49)          kind = K_BULK_EN;
    else                             kind = K_BAD;
  end
endmodule

// File: rtl/hpc_slot_apply.sv
module hpc_slot_apply
  import hpc_cmd_pkg::*;
(
  input  slot_ctl_t cur,
  input  slot_ctl_t req,
  output slot_ctl_t nxt,
  output logic      reject,
  output logic      turn_off
);
  logic was_off;
  logic is_off;

  always_comb begin
    reject   = (cur.st == ST_EN) && (req.st == ST_PWR);
    nxt.st   = (req.st   == ST_NONE)  ? cur.st   : req.st;
    nxt.pwr  = (req.pwr  == LED_NONE) ? cur.pwr  : req.pwr;
    nxt.attn = (req.attn == LED_NONE) ? cur.attn : req.attn;
    was_off  = (cur.st == ST_DIS) && (cur.pwr == LED_OFF);
    is_off   = (nxt.st == ST_DIS) && (nxt.pwr == LED_OFF);
    turn_off = !reject && !was_off && is_off;
  end
endmodule

// File: rtl/hpc_slot_bank.sv
module hpc_slot_bank
  import hpc_cmd_pkg::*;
#(
  parameter int NSLOT = 8,
  parameter int IDXW  = 3
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  upd_en,
  input  logic [IDXW-1:0]       upd_idx,
  input  slot_ctl_t             upd_ctl,
  input  logic                  upd_off,
  input  logic                  mrl_wr_en,
  input  logic [IDXW-1:0]       mrl_wr_idx,
  input  logic                  mrl_wr_open,
  input  logic [NSLOT-1:0]      evt_clr,
  output slot_ctl_t [NSLOT-1:0] ctl,
  output logic [NSLOT-1:0]      mrl_open,
  output logic [2*NSLOT-1:0]    prsnt,
  output logic [NSLOT-1:0]      evt_mrl,
  output logic [NSLOT-1:0]      evt_prsnt
);
  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    slot_ctl_t  ctl_q, ctl_d;
    logic       mrl_q, mrl_d;
    logic [1:0] prs_q, prs_d;
    logic       em_q, em_d, ep_q, ep_d;
    logic       hit_upd, hit_mrl, slot_we;

    assign hit_upd = upd_en    && (upd_idx    == IDXW'(i));
    assign hit_mrl = mrl_wr_en && (mrl_wr_idx == IDXW'(i));
    assign slot_we = hit_upd || hit_mrl || evt_clr[i];

    always_comb begin
      ctl_d = ctl_q;
      mrl_d = mrl_q;
      prs_d = prs_q;
      em_d  = em_q & ~evt_clr[i];
      ep_d  = ep_q & ~evt_clr[i];
      if (hit_mrl) begin
        mrl_d = mrl_wr_open;
        prs_d = mrl_wr_open ? PRS_EMPTY : PRS_LOW;
      end
      if (hit_upd) begin
        ctl_d = upd_ctl;
        if (upd_off) begin
          mrl_d = 1'b1;
          prs_d = PRS_EMPTY;
          em_d  = 1'b1;
          ep_d  = 1'b1;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctl_q <= slot_ctl_t'{st: ST_DIS, pwr: LED_OFF, attn: LED_OFF};
        mrl_q <= 1'b1;
        prs_q <= PRS_EMPTY;
        em_q  <= 1'b0;
        ep_q  <= 1'b0;
      end else if (slot_we) begin
        ctl_q <= ctl_d;
        mrl_q <= mrl_d;
        prs_q <= prs_d;
        em_q  <= em_d;
        ep_q  <= ep_d;
      end
    end

    assign ctl[i]         = ctl_q;
    assign mrl_open[i]    = mrl_q;
    assign prsnt[2*i +: 2] = prs_q;
    assign evt_mrl[i]     = em_q;
    assign evt_prsnt[i]   = ep_q;
  end
endmodule

// File: rtl/hpc_cmd_ctrl.sv
module hpc_cmd_ctrl
  import hpc_cmd_pkg::*;
#(
  parameter  int NSLOT = 8,
  localparam int IDXW  = (NSLOT > 1) ? $clog2(NSLOT) : 1
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [7:0]           cmd_code,
  input  logic [7:0]           cmd_target,
  input  logic                 mrl_wr_en,
  input  logic [IDXW-1:0]      mrl_wr_idx,
  input  logic                 mrl_wr_open,
  input  logic [NSLOT-1:0]     evt_clr,
  input  logic                 det_clr,
  output logic [2*NSLOT-1:0]   slot_state,
  output logic [2*NSLOT-1:0]   slot_pwr_led,
  output logic [2*NSLOT-1:0]   slot_attn_led,
  output logic [NSLOT-1:0]     slot_mrl_open,
  output logic [2*NSLOT-1:0]   slot_prsnt,
  output logic [NSLOT-1:0]     evt_mrl,
  output logic [NSLOT-1:0]     evt_prsnt,
  output logic                 sts_busy,
  output logic                 sts_inv_cmd,
  output logic                 sts_inv_mode,
  output logic                 cmd_detected,
  output logic [2:0]           bus_speed,
  output logic                 rm_req,
  output logic [IDXW-1:0]      rm_idx
);
  localparam logic [4:0]      TGT_MAX  = 5'(NSLOT);
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NSLOT - 1);

  cmd_kind_e             kind;
  slot_ctl_t             dec_req, req, bulk_req, cur, nxt;
  slot_ctl_t [NSLOT-1:0] ctl;
  logic [2:0]            dec_speed;
  logic                  reject, turn_off, upd_en;
  logic                  accept, tgt_ok, any_en, cur_mrl;
  logic [4:0]            tgt, tgt_m1;
  logic [IDXW-1:0]       sel_idx;

  logic                  busy_q, busy_d, bulk_en_q, bulk_en_d;
  logic [IDXW-1:0]       idx_q, idx_d, rm_idx_q, rm_idx_d;
  logic                  inv_cmd_q, inv_cmd_d, inv_mode_q, inv_mode_d;
  logic                  det_q, det_d, rm_q, rm_d;
  logic [2:0]            speed_q, speed_d;

  hpc_cmd_decode u_dec (
    .code (cmd_code),
    .kind (kind),
    .req  (dec_req),
    .speed(dec_speed)
  );

  assign accept  = cmd_valid && !busy_q;
  assign tgt     = cmd_target[4:0];
  assign tgt_m1  = tgt - 5'd1;
  assign tgt_ok  = (tgt != 5'd0) && (tgt <= TGT_MAX);
  assign sel_idx = busy_q ? idx_q : tgt_m1[IDXW-1:0];

  always_comb begin
    cur     = '0;
    cur_mrl = 1'b0;
    any_en  = 1'b0;
    for (int i = 0; i < NSLOT; i++) begin
      if (sel_idx == IDXW'(i)) begin
        cur     = ctl[i];
        cur_mrl = slot_mrl_open[i];
      end
      if (ctl[i].st == ST_EN) any_en = 1'b1;
    end
  end

  always_comb begin
    bulk_req.attn = LED_NONE;
    if (cur_mrl) begin
      bulk_req.st  = ST_NONE;
      bulk_req.pwr = LED_OFF;
    end else begin
      bulk_req.st  = bulk_en_q ? ST_EN : ST_PWR;
      bulk_req.pwr = LED_ON;
    end
    req = busy_q ? bulk_req : dec_req;
  end

  hpc_slot_apply u_apply (
    .cur     (cur),
    .req     (req),
    .nxt     (nxt),
    .reject  (reject),
    .turn_off(turn_off)
  );

  assign upd_en = busy_q ? !reject
                         : (accept && (kind == K_SLOT) && tgt_ok && !reject);

  hpc_slot_bank #(.NSLOT(NSLOT), .IDXW(IDXW)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_en     (upd_en),
    .upd_idx    (sel_idx),
    .upd_ctl    (nxt),
    .upd_off    (turn_off),
    .mrl_wr_en  (mrl_wr_en),
    .mrl_wr_idx (mrl_wr_idx),
    .mrl_wr_open(mrl_wr_open),
    .evt_clr    (evt_clr),
    .ctl        (ctl),
    .mrl_open   (slot_mrl_open),
    .prsnt      (slot_prsnt),
    .evt_mrl    (evt_mrl),
    .evt_prsnt  (evt_prsnt)
  );

  always_comb begin
    busy_d     = busy_q;
    bulk_en_d  = bulk_en_q;
    idx_d      = idx_q;
    inv_cmd_d  = inv_cmd_q;
    inv_mode_d = inv_mode_q;
    speed_d    = speed_q;
    det_d      = det_q & ~det_clr;
    rm_d       = upd_en && turn_off;
    rm_idx_d   = sel_idx;
    if (accept) begin
      inv_cmd_d  = 1'b0;
      inv_mode_d = 1'b0;
      unique case (kind)
        K_SLOT: begin
          inv_cmd_d = !tgt_ok || reject;
          det_d     = 1'b1;
        end
        K_SPEED: begin
          if (dec_speed == 3'd0) speed_d = dec_speed;
          else                   inv_mode_d = 1'b1;
          det_d = 1'b1;
        end
        K_BULK_PWR, K_BULK_EN: begin
          if (any_en) begin
            inv_cmd_d = 1'b1;
            det_d     = 1'b1;
          end else begin
            busy_d    = 1'b1;
            idx_d     = '0;
            bulk_en_d = (kind == K_BULK_EN);
          end
        end
        default: begin
          inv_cmd_d = 1'b1;
          det_d     = 1'b1;
        end
      endcase
    end else if (busy_q) begin
      if (idx_q == LAST_IDX) begin
        busy_d = 1'b0;
        det_d  = 1'b1;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      bulk_en_q  <= 1'b0;
      idx_q      <= '0;
      inv_cmd_q  <= 1'b0;
      inv_mode_q <= 1'b0;
      det_q      <= 1'b0;
      speed_q    <= 3'd0;
      rm_q       <= 1'b0;
      rm_idx_q   <= '0;
    end else begin
      busy_q     <= busy_d;
      bulk_en_q  <= bulk_en_d;
      idx_q      <= idx_d;
      inv_cmd_q  <= inv_cmd_d;
      inv_mode_q <= inv_mode_d;
      det_q      <= det_d;
      speed_q    <= speed_d;
      rm_q       <= rm_d;
      rm_idx_q   <= rm_idx_d;
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_flat
    assign slot_state[2*g +: 2]    = ctl[g].st;
    assign slot_pwr_led[2*g +: 2]  = ctl[g].pwr;
    assign slot_attn_led[2*g +: 2] = ctl[g].attn;
  end

  assign sts_busy     = busy_q;
  assign sts_inv_cmd  = inv_cmd_q;
  assign sts_inv_mode = inv_mode_q;
  assign cmd_detected = det_q;
  assign bus_speed    = speed_q;
  assign rm_req       = rm_q;
  assign rm_idx       = rm_idx_q;
endmodule

// File: rtl/hpc_cmd_ctrl_chk.sv
module hpc_cmd_ctrl_chk #(
  parameter int NSLOT = 8,
  parameter int IDXW  = 3
)(
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic [2*NSLOT-1:0] slot_state,
  input logic [2*NSLOT-1:0] slot_pwr_led,
  input logic [NSLOT-1:0]   slot_mrl_open,
  input logic [2*NSLOT-1:0] slot_prsnt,
  input logic               sts_busy,
  input logic               sts_inv_cmd,
  input logic               sts_inv_mode,
  input logic               cmd_detected,
  input logic               rm_req,
  input logic [IDXW-1:0]    rm_idx
);
  for (genvar i = 0; i < NSLOT; i++) begin : g_chk
    assert_rm_slot_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rm_req && rm_idx == IDXW'(i)) |->
        (slot_state[2*i +: 2] == 2'd3 && slot_pwr_led[2*i +: 2] == 2'd3 && slot_mrl_open[i]));

    assert_latch_presence_R5: assert property (@(posedge clk) disable iff (!rst_n)
      slot_mrl_open[i] == (slot_prsnt[2*i +: 2] == 2'd3));
  end

  assert_busy_no_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sts_busy |-> (!sts_inv_cmd && !sts_inv_mode));

  assert_walk_end_detect_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sts_busy) |-> cmd_detected);

  assert_busy_ignores_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_busy && cmd_valid) |=> !sts_inv_cmd);

  assert_errors_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(sts_inv_cmd && sts_inv_mode));
endmodule

bind hpc_cmd_ctrl hpc_cmd_ctrl_chk #(.NSLOT(NSLOT), .IDXW(IDXW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_valid    (cmd_valid),
  .slot_state   (slot_state),
  .slot_pwr_led (slot_pwr_led),
  .slot_mrl_open(slot_mrl_open),
  .slot_prsnt   (slot_prsnt),
  .sts_busy     (sts_busy),
  .sts_inv_cmd  (sts_inv_cmd),
  .sts_inv_mode (sts_inv_mode),
  .cmd_detected (cmd_detected),
  .rm_req       (rm_req),
  .rm_idx       (rm_idx)
);

// File: tb/hpc_cmd_ctrl_test.sv
module hpc_cmd_ctrl_test;
  localparam int CLK_P = 10;
  localparam int NS    = 3;
  localparam int IW    = 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            cmd_valid;
  logic [7:0]      cmd_code, cmd_target;
  logic            mrl_wr_en, mrl_wr_open;
  logic [IW-1:0]   mrl_wr_idx;
  logic [NS-1:0]   evt_clr;
  logic            det_clr;
  logic [2*NS-1:0] slot_state, slot_pwr_led, slot_attn_led, slot_prsnt;
  logic [NS-1:0]   slot_mrl_open, evt_mrl, evt_prsnt;
  logic            sts_busy, sts_inv_cmd, sts_inv_mode, cmd_detected, rm_req;
  logic [2:0]      bus_speed;
  logic [IW-1:0]   rm_idx;

  int n_chk  = 0;
  int n_fail = 0;

  // model of the slots, built from the requirements
  logic [1:0] m_st [NS];
  logic [1:0] m_pwr [NS];
  logic [1:0] m_attn [NS];
  logic [1:0] m_prs [NS];
  logic       m_mrl [NS];
  logic       m_evm [NS];
  logic       m_evp [NS];
  logic       m_busy, m_bulk_en, m_inv_c, m_inv_m, m_det, m_rm;
  int         m_idx, m_rm_idx;
  logic [2:0] m_speed;

  always #(CLK_P/2) clk = ~clk;

  hpc_cmd_ctrl #(.NSLOT(NS)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_target(cmd_target), .mrl_wr_en(mrl_wr_en), .mrl_wr_idx(mrl_wr_idx),
    .mrl_wr_open(mrl_wr_open), .evt_clr(evt_clr), .det_clr(det_clr),
    .slot_state(slot_state), .slot_pwr_led(slot_pwr_led),
    .slot_attn_led(slot_attn_led), .slot_mrl_open(slot_mrl_open),
    .slot_prsnt(slot_prsnt), .evt_mrl(evt_mrl), .evt_prsnt(evt_prsnt),
    .sts_busy(sts_busy), .sts_inv_cmd(sts_inv_cmd), .sts_inv_mode(sts_inv_mode),
    .cmd_detected(cmd_detected), .bus_speed(bus_speed), .rm_req(rm_req),
    .rm_idx(rm_idx)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic compare_all(input string ctx);
    logic [2*NS-1:0] e_st, e_pw, e_at, e_pr;
    logic [NS-1:0]   e_ml, e_em, e_ep;
    for (int i = 0; i < NS; i++) begin
      e_st[2*i +: 2] = m_st[i];
      e_pw[2*i +: 2] = m_pwr[i];
      e_at[2*i +: 2] = m_attn[i];
      e_pr[2*i +: 2] = m_prs[i];
      e_ml[i] = m_mrl[i];
      e_em[i] = m_evm[i];
      e_ep[i] = m_evp[i];
    end
    chk({ctx, " R2 slot state"}, 32'(slot_state), 32'(e_st));
    chk({ctx, " R3 power lamps"}, 32'(slot_pwr_led), 32'(e_pw));
    chk({ctx, " R3 attention lamps"}, 32'(slot_attn_led), 32'(e_at));
    chk({ctx, " R5 latch/presence"}, {16'(slot_mrl_open), 16'(slot_prsnt)}, {16'(e_ml), 16'(e_pr)});
    chk({ctx, " R5 events"}, {16'(evt_mrl), 16'(evt_prsnt)}, {16'(e_em), 16'(e_ep)});
    chk({ctx, " R4 invalid-command"}, 32'(sts_inv_cmd), 32'(m_inv_c));
    chk({ctx, " R6 invalid-mode/speed"}, {28'(sts_inv_mode), bus_speed}, {28'(m_inv_m), m_speed});
    chk({ctx, " R1 detected"}, 32'(cmd_detected), 32'(m_det));
    chk({ctx, " R9 busy"}, 32'(sts_busy), 32'(m_busy));
    chk({ctx, " R10 removal"}, {16'(rm_req), 16'(rm_req ? rm_idx : 0)},
        {16'(m_rm), 16'(m_rm ? m_rm_idx : 0)});
  endtask

  task automatic m_slot(input int i, input int rs, input int rp, input int ra, output bit rej);
    bit old_off;
    rej = 0;
    if (m_st[i] == 2 && rs == 1) begin
      rej = 1;
      return;
    end
    old_off = (m_st[i] == 3 && m_pwr[i] == 3);
    if (rs != 0) m_st[i]   = 2'(rs);
    if (rp != 0) m_pwr[i]  = 2'(rp);
    if (ra != 0) m_attn[i] = 2'(ra);
    if (!old_off && m_st[i] == 3 && m_pwr[i] == 3) begin
      m_mrl[i] = 1; m_prs[i] = 3; m_evm[i] = 1; m_evp[i] = 1;
      m_rm = 1; m_rm_idx = i;
    end
  endtask

  task automatic m_accept(input int code, input int tb);
    int t;
    bit rej, any;
    t = tb & 31;
    m_rm = 0; m_inv_c = 0; m_inv_m = 0;
    if (code < 64) begin
      if (t == 0 || t > NS) m_inv_c = 1;
      else begin
        m_slot(t - 1, code & 3, (code >> 2) & 3, (code >> 4) & 3, rej);
        if (rej) m_inv_c = 1;
      end
      m_det = 1;
    end else if (code <= 71) begin
      if ((code & 7) != 0) m_inv_m = 1;
      else m_speed = 0;
      m_det = 1;
    end else if (code == 72 || code == 73) begin
      any = 0;
      for (int i = 0; i < NS; i++) if (m_st[i] == 2) any = 1;
      if (any) begin m_inv_c = 1; m_det = 1; end
      else begin m_busy = 1; m_idx = 0; m_bulk_en = (code == 73); end
    end else begin
      m_inv_c = 1; m_det = 1;
    end
  endtask

  task automatic m_bulk_step();
    bit rej;
    m_rm = 0;
    if (m_mrl[m_idx]) m_slot(m_idx, 0, 3, 0, rej);
    else              m_slot(m_idx, m_bulk_en ? 2 : 1, 1, 0, rej);
    if (m_idx == NS - 1) begin m_busy = 0; m_det = 1; end
    else m_idx++;
  endtask

  // inject: drive a strobe (bad code) during the first bulk step
  task automatic run_cmd(input int code, input int tb, input string ctx, input bit inject);
    @(negedge clk);
    cmd_valid = 1; cmd_code = 8'(code); cmd_target = 8'(tb);
    m_accept(code, tb);
    @(negedge clk);
    cmd_valid = 0;
    compare_all(ctx);
    while (m_busy) begin
      if (inject && m_idx == 0) begin
        cmd_valid = 1; cmd_code = 8'hFF; cmd_target = 8'h01;
      end
      m_bulk_step();
      @(negedge clk);
      cmd_valid = 0;
      compare_all({ctx, " walk"});
    end
  endtask

  task automatic mrl_write(input int i, input bit open);
    @(negedge clk);
    mrl_wr_en = 1; mrl_wr_idx = IW'(i); mrl_wr_open = open;
    m_rm = 0;
    m_mrl[i] = open; m_prs[i] = open ? 2'd3 : 2'd0;
    @(negedge clk);
    mrl_wr_en = 0;
    compare_all("R13 latch write");
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL R9 watchdog expired: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; cmd_valid = 0; cmd_code = 0; cmd_target = 0;
    mrl_wr_en = 0; mrl_wr_idx = 0; mrl_wr_open = 0; evt_clr = 0; det_clr = 0;
    for (int i = 0; i < NS; i++) begin
      m_st[i] = 3; m_pwr[i] = 3; m_attn[i] = 3; m_prs[i] = 3;
      m_mrl[i] = 1; m_evm[i] = 0; m_evp[i] = 0;
    end
    m_busy = 0; m_bulk_en = 0; m_inv_c = 0; m_inv_m = 0; m_det = 0; m_rm = 0;
    m_idx = 0; m_rm_idx = 0; m_speed = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare_all("R12 reset");

    // R13: close latches of slots 0 and 2
    mrl_write(0, 0);
    mrl_write(2, 0);

    // R8/R9: power all, with a strobe ignored during the walk
    run_cmd(8'h48, 0, "R8 power-all", 1);
    // R8: enable all
    run_cmd(8'h49, 0, "R8 enable-all", 0);
    // R7: bulk rejected while slots are enabled
    run_cmd(8'h48, 0, "R7 rejected bulk", 0);
    // R3: slot 2 (target 2) powered only, lamps kept
    run_cmd(8'h01, 2, "R3 power-only", 0);
    // R10/R5: disable with both lamps off turns slot index 1 off
    run_cmd(8'h3F, 2, "R10 turn-off", 0);
    // R4: powered-only on an enabled slot is refused
    run_cmd(8'h05, 1, "R4 refuse power-only", 0);
    // R4: out-of-range target, R2: upper target bits ignored
    run_cmd(8'h0A, 8'hE4, "R4 bad target", 0);
    run_cmd(8'h0A, 8'hE3, "R2 masked target", 0);
    // R6: speed codes
    run_cmd(8'h41, 1, "R6 bad speed", 0);
    run_cmd(8'h40, 1, "R6 speed zero", 0);
    // R11: undefined code
    run_cmd(8'h4A, 1, "R11 undefined", 0);

    // sweep every code against the model
    for (int c = 0; c < 256; c++) begin
      int t;
      t = (c * 5 + c / 64) % 7;
      run_cmd(c, t | ((c % 8) << 5), "R2 sweep", 0);
      if (c % 16 == 15) mrl_write(c % 3, 1'((c / 16) % 2));
    end

    // R5: event clear
    @(negedge clk);
    evt_clr = '1; m_rm = 0;
    for (int i = 0; i < NS; i++) begin m_evm[i] = 0; m_evp[i] = 0; end
    @(negedge clk);
    evt_clr = '0;
    compare_all("R5 event clear");

    // R1: detected clear
    @(negedge clk);
    det_clr = 1; m_det = 0;
    @(negedge clk);
    det_clr = 0;
    compare_all("R1 detected clear");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule